// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned or two's-complement operands and an incoming carry in one combinational pass. It returns the wrapped sum and the carry out of the top bit. The operand is split into equal slices. Every slice forms a generate term (both operand bits set) and a propagate term (either operand bit set) for each bit position. From those terms the slice computes every carry inside itself as a flat sum-of-products, so no carry ripples from one bit to the next.

Each slice also reduces its terms to one slice-level generate and one slice-level propagate. A second lookahead level takes these slice-level pairs and the external carry. From them it produces the carry into every slice above the lowest one and the final carry out, again as flat sum-of-products rather than a chain. The same carry network is used at both levels. Sum bits are the exclusive-OR of the two operand bits and the carry into that position, because the OR-style propagate term cannot stand in for the half-sum. The longest path therefore ends at the sum bit of the top position, not at the carry out.

The slice width and the number of slices are parameters. The defaults, four slices of four bits, give a 16-bit adder. The block holds no state and is meant to sit inside a clocked datapath.

Top module: `gcla_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `carry_i`) modulo 2^WIDTH for every input combination, with WIDTH = GROUP_W * NUM_GROUPS (16 by default).
- R2: `carry_o` equals bit WIDTH of the (WIDTH+1)-bit value `a_i` + `b_i` + `carry_i`.
- R3: With `a_i` all ones, `b_i` zero and `carry_i` = 1, `sum_o` is zero and `carry_o` is 1: the input carry crosses every slice.
- R4: The carry entering slice g (bits g*GROUP_W upward) equals the carry out of adding the lower g*GROUP_W bits of both operands and `carry_i`; an operand that fills a lower slice with ones and adds one therefore yields a single one at that slice's lowest bit.
- R5: Positions where exactly one operand bit is set pass a carry on; alternating operands 0xAAAA and 0x5555 with `carry_i` = 1 give sum 0 and `carry_o` = 1, and with `carry_i` = 0 give 0xFFFF and `carry_o` = 0.
- R6: A generate at bit 0 (`a_i` = 1) with every other position propagating (`b_i` all ones) gives sum 0 and `carry_o` = 1.
- R7: With both operands zero, `sum_o` equals `carry_i` in bit 0 with all other bits zero, and `carry_o` is 0.
- R8: GROUP_W and NUM_GROUPS must both be at least 1; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Incoming carry, added at bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that starts at the input or at bit 0 and has to cross all four slices through propagate terms alone. In that case every slice-level propagate and the second-level product chain must be true at once. Uniform random operands almost never line up this way, so the stimulus builds it on purpose. It uses all-ones operands against zero, complementary alternating patterns, and lower-slice-full patterns that set a carry into exactly one slice boundary. Random operands with random input carries then cover the mixed generate and propagate cases.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
   function automatic int calc_width(input int group_w, input int num_groups);
      return group_w * num_groups;
   endfunction
endpackage

// File: rtl/gcla_bit_pg.sv
module gcla_bit_pg (
   input  logic op_a_i,
   input  logic op_b_i,
   output logic gen_o,
   output logic prop_o,
   output logic half_o
);
   assign gen_o  = op_a_i & op_b_i;
   assign prop_o = op_a_i | op_b_i;
   assign half_o = op_a_i ^ op_b_i;
endmodule

// File: rtl/gcla_carry_net.sv
// Flat lookahead network: each carry is a sum of products over lower terms.
module gcla_carry_net #(
   parameter int N = 4
) (
   input  logic [N-1:0] gen_i,
   input  logic [N-1:0] prop_i,
   input  logic         cin_i,
   output logic [N-1:0] cpos_o,
   output logic         grp_gen_o,
   output logic         grp_prop_o
);
   always_comb begin
      cpos_o[0] = cin_i;
      for (int j = 1; j < N; j++) begin
         logic acc;
         logic chain;
         acc = 1'b0;
         for (int k = 0; k < j; k++) begin
            logic term;
            term = gen_i[k];
            for (int m = k + 1; m < j; m++) term = term & prop_i[m];
            acc = acc | term;
         end
         chain = cin_i;
         for (int m = 0; m < j; m++) chain = chain & prop_i[m];
         cpos_o[j] = acc | chain;
      end
   end

   always_comb begin
      grp_gen_o  = 1'b0;
      grp_prop_o = 1'b1;
      for (int k = 0; k < N; k++) begin
         logic term;
         term = gen_i[k];
         for (int m = k + 1; m < N; m++) term = term & prop_i[m];
         grp_gen_o  = grp_gen_o | term;
         grp_prop_o = grp_prop_o & prop_i[k];
      end
   end
endmodule

// File: rtl/gcla_group.sv
module gcla_group #(
   parameter int GROUP_W = 4
) (
   input  logic [GROUP_W-1:0] op_a_i,
   input  logic [GROUP_W-1:0] op_b_i,
   input  logic               cin_i,
   output logic [GROUP_W-1:0] sum_o,
   output logic               grp_gen_o,
   output logic               grp_prop_o
);
   logic [GROUP_W-1:0] gen_w;
   logic [GROUP_W-1:0] prop_w;
   logic [GROUP_W-1:0] half_w;
   logic [GROUP_W-1:0] cpos_w;

   for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
      gcla_bit_pg bit_i (
         .op_a_i (op_a_i[i]),
         .op_b_i (op_b_i[i]),
         .gen_o  (gen_w[i]),
         .prop_o (prop_w[i]),
         .half_o (half_w[i])
      );
   end

   gcla_carry_net #(.N(GROUP_W)) net_i (
      .gen_i      (gen_w),
      .prop_i     (prop_w),
      .cin_i      (cin_i),
      .cpos_o     (cpos_w),
      .grp_gen_o  (grp_gen_o),
      .grp_prop_o (grp_prop_o)
   );

   assign sum_o = half_w ^ cpos_w;
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder #(
   parameter  int GROUP_W    = 4,
   parameter  int NUM_GROUPS = 4,
   localparam int WIDTH      = gcla_pkg::calc_width(GROUP_W, NUM_GROUPS)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o
);
   // R8: elaboration-time parameter check
   if (GROUP_W < 1 || NUM_GROUPS < 1) begin : g_bad_param
      $error("gcla_adder: GROUP_W and NUM_GROUPS must be at least 1");
   end

   logic [NUM_GROUPS-1:0] grp_gen;
   logic [NUM_GROUPS-1:0] grp_prop;
   logic [NUM_GROUPS-1:0] grp_cin;
   logic                  top_gen;
   logic                  top_prop;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      gcla_group #(.GROUP_W(GROUP_W)) grp_i (
         .op_a_i     (a_i[g*GROUP_W +: GROUP_W]),
         .op_b_i     (b_i[g*GROUP_W +: GROUP_W]),
         .cin_i      (grp_cin[g]),
         .sum_o      (sum_o[g*GROUP_W +: GROUP_W]),
         .grp_gen_o  (grp_gen[g]),
         .grp_prop_o (grp_prop[g])
      );
   end

   // Second level: carries into slices from slice-level terms
   gcla_carry_net #(.N(NUM_GROUPS)) lvl2_i (
      .gen_i      (grp_gen),
      .prop_i     (grp_prop),
      .cin_i      (carry_i),
      .cpos_o     (grp_cin),
      .grp_gen_o  (top_gen),
      .grp_prop_o (top_prop)
   );

   assign carry_o = top_gen | (top_prop & carry_i);
endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
   parameter  int GROUP_W    = 4,
   parameter  int NUM_GROUPS = 4,
   localparam int WIDTH      = GROUP_W * NUM_GROUPS
) (
   input logic [WIDTH-1:0]      a_i,
   input logic [WIDTH-1:0]      b_i,
   input logic                  carry_i,
   input logic [WIDTH-1:0]      sum_o,
   input logic                  carry_o,
   input logic [NUM_GROUPS-1:0] grp_cin
);
   logic [WIDTH:0] ref_full;
   logic           known;

   assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
   assign known    = !$isunknown({a_i, b_i, carry_i});

   always_comb begin
      if (known) begin
         AST_SUM_MATCH: assert (sum_o == ref_full[WIDTH-1:0]); // R1
         AST_CARRY_OUT: assert (carry_o == ref_full[WIDTH]); // R2
         AST_ZERO_OPERANDS: assert (!(a_i == '0 && b_i == '0) || (sum_o == WIDTH'(carry_i) && !carry_o)); // R7
         AST_FULL_PROPAGATE: assert (!(a_i == '1 && b_i == '0 && carry_i) || (sum_o == '0 && carry_o)); // R3
      end
   end

   for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_bnd
      logic [g*GROUP_W:0] low_sum;
      assign low_sum = {1'b0, a_i[g*GROUP_W-1:0]} + {1'b0, b_i[g*GROUP_W-1:0]}
                     + {{(g*GROUP_W){1'b0}}, carry_i};
      always_comb begin
         if (known) begin
            AST_SLICE_CARRY: assert (grp_cin[g] == low_sum[g*GROUP_W]); // R4
         end
      end
   end
endmodule

bind gcla_adder gcla_adder_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) chk_i (
   .a_i     (a_i),
   .b_i     (b_i),
   .carry_i (carry_i),
   .sum_o   (sum_o),
   .carry_o (carry_o),
   .grp_cin (grp_cin)
);

// File: tb/gcla_adder_tb_top.sv
module gcla_adder_tb_top;
   localparam int GW = 4;
   localparam int NG = 4;
   localparam int W  = GW * NG;

   typedef struct {
      logic [W-1:0] exp_sum;
      logic         exp_cout;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;

   item_t queue_q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   always #5 clk = ~clk;

   gcla_adder #(.GROUP_W(GW), .NUM_GROUPS(NG)) dut_i (
      .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
   );

   // Driver: apply operands at a rising edge and push the expected result.
   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic c, input string tag);
      item_t it;
      logic [W:0] full;
      @(posedge clk);
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
      it.exp_sum  = full[W-1:0];
      it.exp_cout = full[W];
      it.tag      = tag;
      a   = x;
      b   = y;
      cin = c;
      queue_q.push_back(it);
   endtask

   // Monitor: compare at the falling edge, away from the driving edge.
   always @(negedge clk) begin
      if (rst_n && queue_q.size() > 0) begin
         item_t it;
         it = queue_q.pop_front();
         n_run++;
         if (sum !== it.exp_sum || cout !== it.exp_cout) begin
            n_fail++;
            $display("FAIL %s: got sum=%h cout=%b, expected sum=%h cout=%b",
                     it.tag, sum, cout, it.exp_sum, it.exp_cout);
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R7 idle state and zero operands
      drive('0, '0, 1'b0, "R7");
      drive('0, '0, 1'b1, "R7");
      // R3 input carry through every slice
      drive('1, '0, 1'b1, "R3");
      drive('0, '1, 1'b1, "R3");
      // R6 generate at bit 0, propagate above
      drive(16'h0001, '1, 1'b0, "R6");
      // R5 alternating patterns
      drive(16'hAAAA, 16'h5555, 1'b1, "R5");
      drive(16'hAAAA, 16'h5555, 1'b0, "R5");
      drive(16'hAAAA, 16'hAAAA, 1'b0, "R5");
      drive(16'h5555, 16'h5555, 1'b1, "R5");
      // R4 carries into each slice boundary
      drive(16'h000F, 16'h0001, 1'b0, "R4");
      drive(16'h00FF, 16'h0000, 1'b1, "R4");
      drive(16'h0FFF, 16'h0001, 1'b0, "R4");
      drive(16'h0F0F, 16'h00F1, 1'b0, "R4");
      // R2 carry out from top-slice generate
      drive(16'h8000, 16'h8000, 1'b0, "R2");
      drive('1, '1, 1'b1, "R2");
      // R1 random operands
      for (int i = 0; i < 300; i++) begin
         drive(W'($urandom), W'($urandom), 1'($urandom), "R1");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cycles;
      cycles = 0;
      while (!done && cycles < 5000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout after %0d cycles, expected completion", cycles);
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule